// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block turns the three address streams of a cartridge bus into physical memory offsets. A CPU program-space address is mapped to a program-ROM offset. A picture-unit pattern address is mapped to a pattern-memory offset. A nametable address is folded into a 2 KiB internal video RAM. The mapping is controlled by a small set of configuration fields that a separate register block holds and presents as levels.

Program space is seen through two 16 KiB windows. In 32 KiB mode the two windows move together as an aligned pair. In 16 KiB mode one window follows the bank register and the other is pinned. The pinned window is either the low one, held at the first bank, or the high one, held at the last bank. Pattern space has two 4 KiB windows. They can either be banked independently or move together as an aligned 8 KiB pair. The nametable fold offers four arrangements: two single-screen layouts, a vertical layout and a horizontal layout. Every output is a pure function of the current inputs.

Top module: `bank_xlate`

## Requirements
- R1: The low bits pass straight through. prg_offset[13:0] equals cpu_addr[13:0], chr_offset[11:0] equals ppu_addr[11:0], and vram_offset[9:0] equals nt_addr[9:0].
- R2: When cfg_prg_16k is 0 (32 KiB mode), prg_offset[17:14] equals {cfg_prg_bank[3:1], cpu_addr[14]}. Bit 0 of the bank register is ignored.
- R3: When cfg_prg_16k is 1 and cpu_addr[14] equals cfg_prg_switch_hi, prg_offset[17:14] equals cfg_prg_bank.
- R4: When cfg_prg_16k is 1 and cpu_addr[14] differs from cfg_prg_switch_hi, prg_offset[17:14] is 4'h0 for the low window (cpu_addr[14]=0) and 4'hF for the high window. The bank register has no effect in that case.
- R5: When cfg_chr_split is 1, chr_offset[16:12] equals cfg_chr_bank0 for ppu_addr[12]=0 and cfg_chr_bank1 for ppu_addr[12]=1.
- R6: When cfg_chr_split is 0, chr_offset[16:12] equals {cfg_chr_bank0[4:1], ppu_addr[12]}. cfg_chr_bank1 and cfg_chr_bank0[0] have no effect.
- R7: cfg_mirror code 0 forces vram_offset[10] to 0. Code 1 forces it to 1.
- R8: cfg_mirror code 2 (vertical) gives vram_offset[10] = nt_addr[10]. Code 3 (horizontal) gives vram_offset[10] = nt_addr[11].
- R9: All outputs follow an input change within the same clock cycle. There is no register on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 15 | CPU program-space address; bit 14 selects the 16 KiB window |
| ppu_addr | input | 13 | Pattern-space address; bit 12 selects the 4 KiB window |
| nt_addr | input | 12 | Nametable address; bits 11:10 select one of four logical screens |
| cfg_prg_bank | input | 4 | Program bank register |
| cfg_prg_16k | input | 1 | 1 = 16 KiB program banking, 0 = 32 KiB |
| cfg_prg_switch_hi | input | 1 | In 16 KiB mode, 1 = high window switchable (low pinned to bank 0), 0 = low switchable (high pinned to last bank) |
| cfg_chr_bank0 | input | 5 | Pattern bank for the low 4 KiB window, or the 8 KiB pair base |
| cfg_chr_bank1 | input | 5 | Pattern bank for the high 4 KiB window |
| cfg_chr_split | input | 1 | 1 = two independent 4 KiB banks, 0 = one 8 KiB bank |
| cfg_mirror | input | 2 | Nametable arrangement: 0 single low, 1 single high, 2 vertical, 3 horizontal |
| prg_offset | output | 18 | Physical program-ROM offset |
| chr_offset | output | 17 | Physical pattern-memory offset |
| vram_offset | output | 11 | Physical internal video RAM offset |

## Verification
Program translation is tried with every combination of size and switch flag, in both windows. Odd and even bank values are used, so that the 32 KiB pairing, the switchable window, and the pins to bank 0 and to bank 15 each produce a different value. Pattern translation uses bank registers whose low bits and contents differ between the two banks. This exposes an independent mode that reads the wrong register, and a paired mode that leaks bank 1 or bank-0 bit 0. Nametable folding is swept over all four logical screens under each arrangement, which separates vertical from horizontal. Directed cases are followed by a random sweep, and a mid-cycle input change shows the outputs have no register.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

  typedef enum logic [1:0] {
    NT_ONE_LOW  = 2'd0,
    NT_ONE_HIGH = 2'd1,
    NT_VERT     = 2'd2,
    NT_HORZ     = 2'd3
  } nt_layout_e;

endpackage

// File: rtl/bx_prg_window.sv
module bx_prg_window #(
  parameter int BANK_W = 4,
  parameter int WIN_W  = 14
) (
  input  logic [WIN_W:0]          cpu_addr,
  input  logic [BANK_W-1:0]       bank_reg,
  input  logic                    size_16k,
  input  logic                    switch_hi,
  output logic [BANK_W+WIN_W-1:0] prg_offset,
  output logic                    region_hi,
  output logic                    pinned_hit
);

  // Chooses the physical 16 KiB bank for one access.
  function automatic logic [BANK_W-1:0] pick_bank(
    input logic              region,
    input logic [BANK_W-1:0] bank,
    input logic              s16,
    input logic              sw_hi
  );
    if (!s16)
      return {bank[BANK_W-1:1], region};
    else if (region == sw_hi)
      return bank;
    else
      return {BANK_W{region}};
  endfunction

  logic [BANK_W-1:0] phys_bank;

  assign region_hi  = cpu_addr[WIN_W];
  assign pinned_hit = size_16k && (region_hi != switch_hi);
  assign phys_bank  = pick_bank(region_hi, bank_reg, size_16k, switch_hi);
  assign prg_offset = {phys_bank, cpu_addr[WIN_W-1:0]};

endmodule

// File: rtl/bx_chr_window.sv
module bx_chr_window #(
  parameter int BANK_W = 5,
  parameter int WIN_W  = 12
) (
  input  logic [WIN_W:0]          ppu_addr,
  input  logic [BANK_W-1:0]       bank_lo,
  input  logic [BANK_W-1:0]       bank_hi,
  input  logic                    split,
  output logic [BANK_W+WIN_W-1:0] chr_offset,
  output logic                    region_hi
);

  // Chooses the physical 4 KiB bank for one access.
  function automatic logic [BANK_W-1:0] pick_bank(
    input logic              region,
    input logic [BANK_W-1:0] b_lo,
    input logic [BANK_W-1:0] b_hi,
    input logic              indep
  );
    if (indep)
      return region ? b_hi : b_lo;
    else
      return {b_lo[BANK_W-1:1], region};
  endfunction

  logic [BANK_W-1:0] phys_bank;

  assign region_hi  = ppu_addr[WIN_W];
  assign phys_bank  = pick_bank(region_hi, bank_lo, bank_hi, split);
  assign chr_offset = {phys_bank, ppu_addr[WIN_W-1:0]};

endmodule

// File: rtl/bx_nt_fold.sv
module bx_nt_fold #(
  parameter int WIN_W = 10
) (
  input  logic [WIN_W+1:0] nt_addr,
  input  logic [1:0]       layout,
  output logic [WIN_W:0]   vram_offset,
  output logic             page_sel
);
  import bank_xlate_pkg::*;

  // Picks which of the two physical 1 KiB pages serves the access.
  function automatic logic page_of(
    input logic [1:0] lay,
    input logic       scr_x,
    input logic       scr_y
  );
    case (lay)
      NT_ONE_LOW:  return 1'b0;
      NT_ONE_HIGH: return 1'b1;
      NT_VERT:     return scr_x;
      default:     return scr_y;
    endcase
  endfunction

  assign page_sel    = page_of(layout, nt_addr[WIN_W], nt_addr[WIN_W+1]);
  assign vram_offset = {page_sel, nt_addr[WIN_W-1:0]};

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int PRG_BANK_W = 4,
  parameter int PRG_WIN_W  = 14,
  parameter int CHR_BANK_W = 5,
  parameter int CHR_WIN_W  = 12,
  parameter int NT_WIN_W   = 10
) (
  input  logic [PRG_WIN_W:0]                cpu_addr,
  input  logic [CHR_WIN_W:0]                ppu_addr,
  input  logic [NT_WIN_W+1:0]               nt_addr,
  input  logic [PRG_BANK_W-1:0]             cfg_prg_bank,
  input  logic                              cfg_prg_16k,
  input  logic                              cfg_prg_switch_hi,
  input  logic [CHR_BANK_W-1:0]             cfg_chr_bank0,
  input  logic [CHR_BANK_W-1:0]             cfg_chr_bank1,
  input  logic                              cfg_chr_split,
  input  logic [1:0]                        cfg_mirror,
  output logic [PRG_BANK_W+PRG_WIN_W-1:0]   prg_offset,
  output logic [CHR_BANK_W+CHR_WIN_W-1:0]   chr_offset,
  output logic [NT_WIN_W:0]                 vram_offset
);

  // Named internal events, observed by the bound checker.
  logic prg_region_hi;
  logic prg_pinned_hit;
  logic chr_region_hi;
  logic nt_page_sel;

  bx_prg_window #(.BANK_W(PRG_BANK_W), .WIN_W(PRG_WIN_W)) prg_i (
    .cpu_addr   (cpu_addr),
    .bank_reg   (cfg_prg_bank),
    .size_16k   (cfg_prg_16k),
    .switch_hi  (cfg_prg_switch_hi),
    .prg_offset (prg_offset),
    .region_hi  (prg_region_hi),
    .pinned_hit (prg_pinned_hit)
  );

  bx_chr_window #(.BANK_W(CHR_BANK_W), .WIN_W(CHR_WIN_W)) chr_i (
    .ppu_addr   (ppu_addr),
    .bank_lo    (cfg_chr_bank0),
    .bank_hi    (cfg_chr_bank1),
    .split      (cfg_chr_split),
    .chr_offset (chr_offset),
    .region_hi  (chr_region_hi)
  );

  bx_nt_fold #(.WIN_W(NT_WIN_W)) nt_i (
    .nt_addr     (nt_addr),
    .layout      (cfg_mirror),
    .vram_offset (vram_offset),
    .page_sel    (nt_page_sel)
  );

endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int PRG_BANK_W = 4,
  parameter int PRG_WIN_W  = 14,
  parameter int CHR_BANK_W = 5,
  parameter int CHR_WIN_W  = 12,
  parameter int NT_WIN_W   = 10
) (
  input logic [PRG_WIN_W:0]              cpu_addr,
  input logic [CHR_WIN_W:0]              ppu_addr,
  input logic [NT_WIN_W+1:0]             nt_addr,
  input logic [PRG_BANK_W-1:0]           cfg_prg_bank,
  input logic                            cfg_prg_16k,
  input logic                            cfg_prg_switch_hi,
  input logic [CHR_BANK_W-1:0]           cfg_chr_bank0,
  input logic [CHR_BANK_W-1:0]           cfg_chr_bank1,
  input logic                            cfg_chr_split,
  input logic [1:0]                      cfg_mirror,
  input logic [PRG_BANK_W+PRG_WIN_W-1:0] prg_offset,
  input logic [CHR_BANK_W+CHR_WIN_W-1:0] chr_offset,
  input logic [NT_WIN_W:0]               vram_offset,
  input logic                            prg_pinned_hit,
  input logic                            nt_page_sel
);

  logic [PRG_BANK_W-1:0] prg_bank_seen;
  logic [CHR_BANK_W-1:0] chr_bank_seen;

  assign prg_bank_seen = prg_offset[PRG_BANK_W+PRG_WIN_W-1:PRG_WIN_W];
  assign chr_bank_seen = chr_offset[CHR_BANK_W+CHR_WIN_W-1:CHR_WIN_W];

  always_comb begin
    AST_LOW_BITS_PASS: assert (prg_offset[PRG_WIN_W-1:0] == cpu_addr[PRG_WIN_W-1:0]
        && chr_offset[CHR_WIN_W-1:0] == ppu_addr[CHR_WIN_W-1:0]
        && vram_offset[NT_WIN_W-1:0] == nt_addr[NT_WIN_W-1:0])
      else $error("low bits altered"); // R1
    AST_PRG_PAIRED: assert (cfg_prg_16k
        || (prg_bank_seen[PRG_BANK_W-1:1] == cfg_prg_bank[PRG_BANK_W-1:1]
            && prg_bank_seen[0] == cpu_addr[PRG_WIN_W]))
      else $error("32K pairing wrong"); // R2
    AST_PRG_SWITCHED: assert (!cfg_prg_16k || prg_pinned_hit
        || prg_bank_seen == cfg_prg_bank)
      else $error("switchable window wrong"); // R3
    AST_PRG_PINNED: assert (!prg_pinned_hit
        || prg_bank_seen == {PRG_BANK_W{cpu_addr[PRG_WIN_W]}})
      else $error("pinned window wrong"); // R4
    AST_CHR_SPLIT: assert (!cfg_chr_split
        || chr_bank_seen == (ppu_addr[CHR_WIN_W] ? cfg_chr_bank1 : cfg_chr_bank0))
      else $error("independent chr bank wrong"); // R5
    AST_CHR_PAIRED: assert (cfg_chr_split
        || (chr_bank_seen[0] == ppu_addr[CHR_WIN_W]
            && chr_bank_seen[CHR_BANK_W-1:1] == cfg_chr_bank0[CHR_BANK_W-1:1]))
      else $error("paired chr bank wrong"); // R6
    AST_NT_SINGLE: assert (cfg_mirror[1] || vram_offset[NT_WIN_W] == cfg_mirror[0])
      else $error("single screen page wrong"); // R7
    AST_NT_SPLIT: assert (!cfg_mirror[1]
        || nt_page_sel == (cfg_mirror[0] ? nt_addr[NT_WIN_W+1] : nt_addr[NT_WIN_W]))
      else $error("two screen page wrong"); // R8
  end

endmodule

bind bank_xlate bank_xlate_chk #(
  .PRG_BANK_W (PRG_BANK_W),
  .PRG_WIN_W  (PRG_WIN_W),
  .CHR_BANK_W (CHR_BANK_W),
  .CHR_WIN_W  (CHR_WIN_W),
  .NT_WIN_W   (NT_WIN_W)
) chk_i (
  .cpu_addr          (cpu_addr),
  .ppu_addr          (ppu_addr),
  .nt_addr           (nt_addr),
  .cfg_prg_bank      (cfg_prg_bank),
  .cfg_prg_16k       (cfg_prg_16k),
  .cfg_prg_switch_hi (cfg_prg_switch_hi),
  .cfg_chr_bank0     (cfg_chr_bank0),
  .cfg_chr_bank1     (cfg_chr_bank1),
  .cfg_chr_split     (cfg_chr_split),
  .cfg_mirror        (cfg_mirror),
  .prg_offset        (prg_offset),
  .chr_offset        (chr_offset),
  .vram_offset       (vram_offset),
  .prg_pinned_hit    (prg_pinned_hit),
  .nt_page_sel       (nt_page_sel)
);

// File: tb/bank_xlate_tb_top.sv
`timescale 1ns/1ps
module bank_xlate_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [14:0] cpu_addr;
  logic [12:0] ppu_addr;
  logic [11:0] nt_addr;
  logic [3:0]  cfg_prg_bank;
  logic        cfg_prg_16k;
  logic        cfg_prg_switch_hi;
  logic [4:0]  cfg_chr_bank0;
  logic [4:0]  cfg_chr_bank1;
  logic        cfg_chr_split;
  logic [1:0]  cfg_mirror;
  logic [17:0] prg_offset;
  logic [16:0] chr_offset;
  logic [10:0] vram_offset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bank_xlate dut_i (
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .nt_addr(nt_addr),
    .cfg_prg_bank(cfg_prg_bank), .cfg_prg_16k(cfg_prg_16k),
    .cfg_prg_switch_hi(cfg_prg_switch_hi),
    .cfg_chr_bank0(cfg_chr_bank0), .cfg_chr_bank1(cfg_chr_bank1),
    .cfg_chr_split(cfg_chr_split), .cfg_mirror(cfg_mirror),
    .prg_offset(prg_offset), .chr_offset(chr_offset), .vram_offset(vram_offset)
  );

  // Reference model: plain integer arithmetic on 16K / 4K / 1K units.
  function automatic int ref_prg(int a, int bank, int s16, int sw_hi);
    int win = (a / 16384) % 2;
    int b;
    if (s16 == 0)      b = (bank / 2) * 2 + win;
    else if (win == sw_hi) b = bank;
    else               b = (win == 1) ? 15 : 0;
    return b * 16384 + (a % 16384);
  endfunction

  function automatic int ref_chr(int a, int b0, int b1, int split);
    int win = (a / 4096) % 2;
    int b;
    if (split != 0) b = (win == 1) ? b1 : b0;
    else            b = (b0 / 2) * 2 + win;
    return b * 4096 + (a % 4096);
  endfunction

  function automatic int ref_nt(int a, int lay);
    int page;
    case (lay)
      0: page = 0;
      1: page = 1;
      2: page = (a / 1024) % 2;
      default: page = (a / 2048) % 2;
    endcase
    return page * 1024 + (a % 1024);
  endfunction

  task automatic compare(input string tag);
    int ep, ec, ev;
    ep = ref_prg(int'(cpu_addr), int'(cfg_prg_bank), int'(cfg_prg_16k), int'(cfg_prg_switch_hi));
    ec = ref_chr(int'(ppu_addr), int'(cfg_chr_bank0), int'(cfg_chr_bank1), int'(cfg_chr_split));
    ev = ref_nt(int'(nt_addr), int'(cfg_mirror));
    checks += 3;
    if (int'(prg_offset) != ep) begin
      errors++;
      $display("FAIL %s prg_offset actual=%h expected=%h", tag, prg_offset, ep);
    end
    if (int'(chr_offset) != ec) begin
      errors++;
      $display("FAIL %s chr_offset actual=%h expected=%h", tag, chr_offset, ec);
    end
    if (int'(vram_offset) != ev) begin
      errors++;
      $display("FAIL %s vram_offset actual=%h expected=%h", tag, vram_offset, ev);
    end
  endtask

  // Drive just after a rising edge, compare at the following falling edge.
  task automatic step(input string tag);
    @(negedge clk);
    compare(tag);
    @(posedge clk);
    #0.5;
  endtask

  initial begin
    cpu_addr = '0; ppu_addr = '0; nt_addr = '0;
    cfg_prg_bank = '0; cfg_prg_16k = 1'b0; cfg_prg_switch_hi = 1'b0;
    cfg_chr_bank0 = '0; cfg_chr_bank1 = '0; cfg_chr_split = 1'b0;
    cfg_mirror = '0;
    repeat (2) @(posedge clk);
    #0.5;
    step("R1 idle");

    // Program windows: every size/flag pairing, both windows, odd and even banks.
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 2; f++)
        for (int w = 0; w < 2; w++)
          for (int b = 0; b < 16; b += 5) begin
            cfg_prg_16k = s[0]; cfg_prg_switch_hi = f[0];
            cfg_prg_bank = b[3:0];
            cpu_addr = {w[0], 14'h2A5C ^ 14'(b * 97)};
            if (s == 0)      step("R2 prg 32K pair");
            else if (w == f) step("R3 prg switchable window");
            else             step("R4 prg pinned window");
          end

    // Pattern windows: distinct bank contents and odd low bits.
    for (int sp = 0; sp < 2; sp++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 3; k++) begin
          cfg_chr_split = sp[0];
          cfg_chr_bank0 = 5'(5'h13 + k * 7);
          cfg_chr_bank1 = 5'(5'h0A + k * 11);
          ppu_addr = {w[0], 12'(12'hF01 + k * 301)};
          if (sp == 1) step("R5 chr independent");
          else         step("R6 chr paired");
        end

    // Nametable: each layout against all four logical screens.
    for (int m = 0; m < 4; m++)
      for (int scr = 0; scr < 4; scr++) begin
        cfg_mirror = m[1:0];
        nt_addr = {scr[1:0], 10'(10'h155 + scr * 77)};
        if (m < 2) step("R7 single screen");
        else       step("R8 two screen");
      end

    // Combinational path: change inputs mid-cycle, sample shortly after.
    @(negedge clk);
    cpu_addr = 15'h7FFF; cfg_prg_16k = 1'b1; cfg_prg_switch_hi = 1'b0;
    cfg_prg_bank = 4'h6; cfg_mirror = 2'd3; nt_addr = 12'h800;
    #0.5;
    compare("R9 same-cycle response");
    @(posedge clk);
    #0.5;

    // Random sweep over every field.
    for (int i = 0; i < 300; i++) begin
      cpu_addr = 15'($urandom); ppu_addr = 13'($urandom); nt_addr = 12'($urandom);
      cfg_prg_bank = 4'($urandom); cfg_prg_16k = 1'($urandom);
      cfg_prg_switch_hi = 1'($urandom);
      cfg_chr_bank0 = 5'($urandom); cfg_chr_bank1 = 5'($urandom);
      cfg_chr_split = 1'($urandom); cfg_mirror = 2'($urandom);
      step("R1/R2/R3/R4/R5/R6/R7/R8 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule